// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits on the receive side of an asynchronous serial channel, after the deserialiser. Each completed character arrives as a one-cycle strobe that carries the data byte and three flags: a parity mismatch, a missing stop bit and a break, where a break means the line was held low for a whole frame. The block queues up to 16 characters. Each stored character keeps its own flags. The block also builds an 8-bit line status word that a host processor reads.

The status word follows the oldest stored character, not the newest arrival. Its parity, framing and break bits describe the character the host will pop next. A summary bit reports whether any stored character carries a flag. A sticky bit records characters that were lost because the queue was full. A long break is stored as one character only, and the queue does not fill with zero bytes. The host pops characters with `pop`. It marks a status read with `lsr_rd`, which clears the sticky bits.

Top module: `uart_rx_lsr`

## Requirements
- R1: After a synchronous reset, `lsr` is 0x00, the queue is empty, and the break suppression state is clear.
- R2: Characters leave the queue in arrival order. `rd_data` shows the oldest character. `lsr[0]` is 1 exactly when the queue holds at least one character.
- R3: A character that arrives while the queue holds 16 entries and no pop occurs in the same cycle is discarded, and the stored entries are unchanged. This sets `lsr[1]` on the following cycle.
- R4: `lsr[1]` stays set until a cycle with `lsr_rd` high. If a new overrun occurs in that same cycle, the bit stays set.
- R5: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) equal the flags of the oldest stored character. All three read 0 when the queue is empty. `rd_perr`, `rd_ferr` and `rd_brk` present the same flags.
- R6: After a break character is accepted, later break characters are dropped without being stored and without causing an overrun. This continues until a character arrives with neither the break flag nor the framing flag set.
- R7: `lsr[7]` is 1 while any stored character carries a flag. Once set, it stays 1 after those characters are popped, until a cycle with `lsr_rd`. A read clears it only if no flagged character remains.
- R8: A pop while the queue is empty has no effect.
- R9: When the queue is full and a pop and an arrival happen in the same cycle, both take effect. No overrun is recorded.
- R10: `lsr[5]` and `lsr[6]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received character completes this cycle |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity mismatch on the received byte |
| rx_ferr | input | 1 | Stop bit missing on the received byte |
| rx_brk | input | 1 | Line held low for a whole frame |
| pop | input | 1 | Remove the oldest character |
| lsr_rd | input | 1 | Host reads the status word this cycle |
| rd_data | output | 8 | Oldest stored byte (valid while lsr[0] is 1) |
| rd_perr | output | 1 | Parity flag of the oldest byte |
| rd_ferr | output | 1 | Framing flag of the oldest byte |
| rd_brk | output | 1 | Break flag of the oldest byte |
| lsr | output | 8 | Line status word |

## Verification
Every result shows one clock edge after its stimulus. An arrival, a pop or a status read changes the head outputs and the whole status word just after the edge that samples it. No path in the block takes two cycles. The bench drives each stimulus at a falling edge. It waits for the next rising edge and compares the outputs at the falling edge that follows. At that point it has moved its reference queue and its expected sticky bits by the same single step. This includes the cycles where a read and a new overrun or a new flagged arrival coincide.

// File: rtl/uart_rx_lsr_pkg.sv
package uart_rx_lsr_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    // Positions in the status word; the host software decodes these.
    localparam int LS_READY   = 0;
    localparam int LS_OVERRUN = 1;
    localparam int LS_PARITY  = 2;
    localparam int LS_FRAMING = 3;
    localparam int LS_BREAK   = 4;
    localparam int LS_ANYERR  = 7;

    function automatic logic char_tagged(input rx_char_t c);
        return c.brk | c.ferr | c.perr;
    endfunction

endpackage

// File: rtl/rx_break_gate.sv
module rx_break_gate
    import uart_rx_lsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  rx_char_t in_char,
    output logic     acc_o
);
    logic brk_seen;

    // A repeated break is swallowed until a cleanly stopped character arrives.
    assign acc_o = in_valid && !(in_char.brk && brk_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_seen <= 1'b0;
        end else if (in_valid) begin
            if (in_char.brk)
                brk_seen <= 1'b1;
            else if (!in_char.ferr)
                brk_seen <= 1'b0;
        end
    end

    p_single_break_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_o && in_char.brk) |=> brk_seen);

    p_line_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_char.brk && !in_char.ferr) |=> !brk_seen);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_rx_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  rx_char_t                     wr_char,
    input  logic                         rd_en,
    output rx_char_t                     head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic [$clog2(DEPTH+1)-1:0]   err_cnt_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    rx_char_t             mem [DEPTH];
    logic [PTR_W-1:0]     wr_ptr, rd_ptr;
    logic [CNT_W-1:0]     count, err_cnt;
    logic                 err_in, err_out;

    assign head_o    = mem[rd_ptr];
    assign count_o   = count;
    assign err_cnt_o = err_cnt;
    assign err_in    = wr_en && char_tagged(wr_char);
    assign err_out   = rd_en && char_tagged(mem[rd_ptr]);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr] <= wr_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
            if (rd_en) rd_ptr <= ptr_inc(rd_ptr);
            count   <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
            err_cnt <= err_cnt + CNT_W'(err_in) - CNT_W'(err_out);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < CNT_W'(DEPTH) || rd_en));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (count != '0));

    p_tags_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= count);

    p_order_step_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
    import uart_rx_lsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lsr_rd,
    input  logic     overrun,
    input  logic     not_empty,
    input  logic     tags_present,
    input  rx_char_t head,
    output logic [7:0] lsr_o
);
    logic oe_q, anyerr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q     <= 1'b0;
            anyerr_q <= 1'b0;
        end else begin
            if (overrun)      oe_q <= 1'b1;
            else if (lsr_rd)  oe_q <= 1'b0;
            if (lsr_rd)            anyerr_q <= 1'b0;
            else if (tags_present) anyerr_q <= 1'b1;
        end
    end

    always_comb begin
        lsr_o             = '0;
        lsr_o[LS_READY]   = not_empty;
        lsr_o[LS_OVERRUN] = oe_q;
        lsr_o[LS_PARITY]  = not_empty && head.perr;
        lsr_o[LS_FRAMING] = not_empty && head.ferr;
        lsr_o[LS_BREAK]   = not_empty && head.brk;
        lsr_o[LS_ANYERR]  = anyerr_q || tags_present;
    end

    p_oe_set_r3: assert property (@(posedge clk) disable iff (rst)
        overrun |=> lsr_o[LS_OVERRUN]);

    p_oe_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !overrun) |=> !lsr_o[LS_OVERRUN]);

    p_oe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!lsr_rd && lsr_o[LS_OVERRUN]) |=> lsr_o[LS_OVERRUN]);

    p_anyerr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!lsr_rd && lsr_o[LS_ANYERR]) |=> lsr_o[LS_ANYERR]);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       pop,
    input  logic       lsr_rd,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic [7:0] lsr
);
    localparam int CNT_W = $clog2(DEPTH+1);

    rx_char_t         in_char, head;
    logic             accept, full, rd_en, wr_en, overrun;
    logic [CNT_W-1:0] count, err_cnt;

    assign in_char = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    rx_break_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_char  (in_char),
        .acc_o    (accept)
    );

    assign full    = (count == CNT_W'(DEPTH));
    assign rd_en   = pop && (count != '0);
    assign wr_en   = accept && (!full || rd_en);
    assign overrun = accept && full && !rd_en;

    rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_char   (in_char),
        .rd_en     (rd_en),
        .head_o    (head),
        .count_o   (count),
        .err_cnt_o (err_cnt)
    );

    rx_line_status u_status (
        .clk          (clk),
        .rst          (rst),
        .lsr_rd       (lsr_rd),
        .overrun      (overrun),
        .not_empty    (count != '0),
        .tags_present (err_cnt != '0),
        .head         (head),
        .lsr_o        (lsr)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;

    p_full_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (full && pop && accept) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: tb/uart_rx_lsr_bench.sv
module uart_rx_lsr_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, pop = 0, lsr_rd = 0;
    logic [7:0] rx_data = '0;
    logic [7:0] rd_data, lsr;
    logic rd_perr, rd_ferr, rd_brk;

    int checks = 0;
    int errors = 0;

    // Reference model: entry = {brk, ferr, perr, data}
    logic [10:0] q[$];
    logic m_oe = 0, m_hold = 0, m_brk_seen = 0;

    always #2 clk = ~clk;

    uart_rx_lsr u_uart_rx_lsr (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .pop(pop),
        .lsr_rd(lsr_rd), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .lsr(lsr)
    );

    function automatic logic any_tag();
        foreach (q[i]) if (q[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_lsr();
        logic [7:0] e = '0;
        e[0] = q.size() != 0;
        e[1] = m_oe;
        if (q.size() != 0) begin
            e[2] = q[0][8];
            e[3] = q[0][9];
            e[4] = q[0][10];
        end
        e[7] = m_hold | any_tag();
        return e;
    endfunction

    task automatic compare(input string req);
        logic [7:0] e = exp_lsr();
        checks++;
        if (lsr !== e) begin
            errors++;
            $display("FAIL %s lsr actual %02h expected %02h", req, lsr, e);
        end
        if (q.size() != 0) begin
            checks++;
            if ({rd_brk, rd_ferr, rd_perr, rd_data} !== q[0]) begin
                errors++;
                $display("FAIL %s head actual %03h expected %03h", req,
                         {rd_brk, rd_ferr, rd_perr, rd_data}, q[0]);
            end
        end
    endtask

    // Driver + monitor in one step: drive at falling edge, update model,
    // compare at the next falling edge.
    task automatic step(input logic v, input logic [7:0] d, input logic p,
                        input logic f, input logic b, input logic pp,
                        input logic rd, input string req);
        logic acc, dpop, full, tags_before;
        rx_valid = v; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        pop = pp; lsr_rd = rd;
        acc  = v && !(b && m_brk_seen);
        dpop = pp && q.size() != 0;
        full = q.size() == 16;
        tags_before = any_tag();
        @(posedge clk);
        @(negedge clk);
        rx_valid = 0; pop = 0; lsr_rd = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        if (v) begin
            if (b) m_brk_seen = 1;
            else if (!f) m_brk_seen = 0;
        end
        if (acc && full && !dpop) m_oe = 1;
        else if (rd) m_oe = 0;
        if (rd) m_hold = 0;
        else if (tags_before) m_hold = 1;
        if (dpop) void'(q.pop_front());
        if (acc && (!full || dpop)) q.push_back({b, f, p, d});
        compare(req);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R1");
        checks++;
        if (lsr !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset lsr actual %02h expected 00", lsr);
        end

        // R2 ordering, clean data
        step(1, 8'hA1, 0, 0, 0, 0, 0, "R2");
        step(1, 8'hB2, 0, 0, 0, 0, 0, "R2");
        step(1, 8'hC3, 0, 0, 0, 0, 0, "R2");
        repeat (3) step(0, 0, 0, 0, 0, 1, 0, "R2");

        // R8 pop on empty
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 8'h5A, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, "R8");

        // R3 overrun: fill 16 then one more
        for (int i = 0; i < 16; i++) step(1, 8'(i + 8'h10), 0, 0, 0, 0, 0, "R3");
        step(1, 8'hEE, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        // R4 overrun and read in the same cycle keeps the bit
        step(1, 8'hEF, 0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 0, 0, 1, "R4");
        // R9 full with pop and arrival together
        step(1, 8'h77, 0, 0, 0, 1, 0, "R9");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1, 0, "R3");

        // R5 / R7 flagged entries at the head
        step(1, 8'h01, 0, 0, 0, 0, 0, "R5");
        step(1, 8'h02, 1, 0, 0, 0, 0, "R7");
        step(1, 8'h03, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R7");

        // R6 break suppression
        step(1, 8'h00, 0, 1, 1, 0, 0, "R6");
        step(1, 8'h00, 0, 1, 1, 0, 0, "R6");
        step(1, 8'h00, 0, 1, 1, 0, 0, "R6");
        step(1, 8'h44, 0, 1, 0, 0, 0, "R6");
        step(1, 8'h00, 0, 1, 1, 0, 0, "R6");
        step(1, 8'h55, 0, 0, 0, 0, 0, "R6");
        step(1, 8'h00, 0, 1, 1, 0, 0, "R6");
        repeat (4) step(0, 0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, "R10");

        checks++;
        if (lsr[6:5] !== 2'b00) begin
            errors++;
            $display("FAIL R10 lsr[6:5] actual %b expected 00", lsr[6:5]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule